// File: doc/BRIEF.md
# Johnson-Code Seven-Segment Decoder with Zero Blanking

This block turns the state of a five-stage decade Johnson counter directly into the seven active-high segment drives of one display digit. It does not go through BCD first. The path is purely combinational: the segment outputs follow the count input, the blanking input and the lamp-test input with no clock delay. The counter that produces the code sits outside the block.

Several digits of a display are chained through their blanking pins to hide leading or trailing zeros. The blanking output of one digit feeds the blanking input of its neighbour. Tying a digit's blanking input high forces its zero to show, for example the zero in front of a decimal point. A lamp-test input lights every segment so a broken segment can be seen.

The block carries a count code and not a stream of transfers, so it has no valid/ready handshake. Every pin is a plain level signal.

Top module: `jc_seg_decoder`

## Requirements
- R1: `seg_o` bit 0 drives segment a, bit 1 b, bit 2 c, bit 3 d, bit 4 e, bit 5 f and bit 6 g. A 1 lights the segment. For digits 0 to 9 the patterns are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F. The 6 carries its top tail and the 9 its bottom tail.
- R2: The ten legal codes on `jc_i` (bit 4 down to bit 0) stand for digits 0 to 9 in this order: 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000.
- R3: While `lamp_test_i` is 1, `seg_o` is 0x7F for every value of `jc_i` and `rbi_i`.
- R4: When `rbi_i` is 0, `lamp_test_i` is 0 and `jc_i` is 00000, `seg_o` is 0x00.
- R5: When `rbi_i` is 1 and `jc_i` is 00000, the zero is shown: `seg_o` is 0x3F, or 0x7F under lamp test.
- R6: `rbo_o` is 0 exactly when `rbi_i` is 0 and `jc_i` is 00000. It is 1 in every other case, and it does not depend on `lamp_test_i`.
- R7: A legal nonzero code is never blanked. With lamp test off, `seg_o` shows its digit pattern for either value of `rbi_i`.
- R8: Each of the 22 illegal codes gives `seg_o` = 0x00 when lamp test is off, and gives `rbo_o` = 1.
- R9: Lamp test overrides blanking. With `rbi_i` 0 and `jc_i` 00000, lamp test gives `seg_o` 0x7F while `rbo_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| jc_i | input | 5 | Johnson counter state, bit 4 down to bit 0 |
| rbi_i | input | 1 | Blanking enable from the more significant neighbour. Low permits a zero to be hidden. |
| lamp_test_i | input | 1 | Drives all segments on while high |
| seg_o | output | 7 | Segment drives, bit 0 = a through bit 6 = g, active high |
| rbo_o | output | 1 | Low while this digit is blanked; goes to the next digit's blanking input |

## Verification
The decoder is tried with all 32 codes under each of the four combinations of blanking input and lamp test. This separates the legal codes from the illegal ones, and the zero code from the nonzero codes. Directed cases then isolate the zero code against both blanking levels, and lamp test on a blanked zero. These show whether blanking, forced display and lamp priority are each honoured, and whether the blanking output ignores lamp test. A fixed-seed random stream then mixes the three inputs so that changes from one pattern to the next are also covered.

// File: rtl/jc_seg_pkg.sv
package jc_seg_pkg;
  localparam int JC_W   = 5;
  localparam int DIGITS = 2 * JC_W;
  localparam int SEG_W  = 7;
  localparam int DIG_W  = $clog2(DIGITS);

  typedef logic [JC_W-1:0]  jc_t;
  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [DIG_W-1:0] dig_t;

  // Johnson code for step k: ones fill from bit 0 up, then zeros fill from bit 0 up
  function automatic jc_t jc_code(input int k);
    jc_t c;
    for (int b = 0; b < JC_W; b++) begin
      if (k <= JC_W) c[b] = (b < k);
      else           c[b] = (b >= k - JC_W);
    end
    return c;
  endfunction

  // segment pattern, bit0 = a ... bit6 = g
  function automatic seg_t seg_glyph(input dig_t d);
    case (d)
      4'd0:    return 7'h3F;
      4'd1:    return 7'h06;
      4'd2:    return 7'h5B;
      4'd3:    return 7'h4F;
      4'd4:    return 7'h66;
      4'd5:    return 7'h6D;
      4'd6:    return 7'h7D;
      4'd7:    return 7'h07;
      4'd8:    return 7'h7F;
      4'd9:    return 7'h6F;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/jc_step_match.sv
module jc_step_match
  import jc_seg_pkg::*;
(
  input  logic [JC_W-1:0]  jc_i,
  output logic [DIGITS-1:0] hit_o,
  output logic [DIG_W-1:0]  digit_o,
  output logic              legal_o
);
  for (genvar k = 0; k < DIGITS; k++) begin : g_step
    localparam jc_t CODE = jc_code(k);
    assign hit_o[k] = (jc_i == CODE);
  end

  always_comb begin
    digit_o = '0;
    for (int k = 0; k < DIGITS; k++) begin
      if (hit_o[k]) digit_o = DIG_W'(k);
    end
  end

  assign legal_o = |hit_o;

  // R2: at most one step matches any input code
  always_comb begin
    p_one_step_r2: assert ($onehot0(hit_o))
      else $error("p_one_step_r2: several Johnson steps matched");
  end
endmodule

// File: rtl/jc_glyph_map.sv
module jc_glyph_map
  import jc_seg_pkg::*;
(
  input  logic [DIG_W-1:0] digit_i,
  input  logic             legal_i,
  input  logic             blank_i,
  input  logic             lamp_i,
  output logic [SEG_W-1:0] seg_o
);
  logic [SEG_W-1:0] glyph;

  assign glyph = seg_glyph(digit_i);

  always_comb begin
    if (lamp_i)                 seg_o = '1;
    else if (blank_i || !legal_i) seg_o = '0;
    else                        seg_o = glyph;
  end

  // R8: an illegal code lights nothing unless lamp test is on
  always_comb begin
    if (!legal_i && !lamp_i)
      p_illegal_dark_r8: assert (seg_o == '0)
        else $error("p_illegal_dark_r8: illegal code lit segments");
  end
endmodule

// File: rtl/jc_blank_ctrl.sv
module jc_blank_ctrl (
  input  logic zero_i,
  input  logic rbi_i,
  output logic blank_o,
  output logic rbo_o
);
  assign blank_o = zero_i & ~rbi_i;
  assign rbo_o   = ~blank_o;

  // R6: the chain output only drops when the neighbour allowed blanking
  always_comb begin
    if (!rbo_o)
      p_rbo_needs_rbi_r6: assert (!rbi_i)
        else $error("p_rbo_needs_rbi_r6: rbo low with rbi high");
  end
endmodule

// File: rtl/jc_seg_decoder.sv
module jc_seg_decoder
  import jc_seg_pkg::*;
(
  input  logic [4:0] jc_i,
  input  logic       rbi_i,
  input  logic       lamp_test_i,
  output logic [6:0] seg_o,
  output logic       rbo_o
);
  logic [DIGITS-1:0] hit;
  logic [DIG_W-1:0]  digit;
  logic              legal;
  logic              blank;

  jc_step_match u_match (
    .jc_i    (jc_i),
    .hit_o   (hit),
    .digit_o (digit),
    .legal_o (legal)
  );

  jc_blank_ctrl u_blank (
    .zero_i  (hit[0]),
    .rbi_i   (rbi_i),
    .blank_o (blank),
    .rbo_o   (rbo_o)
  );

  jc_glyph_map u_glyph (
    .digit_i (digit),
    .legal_i (legal),
    .blank_i (blank),
    .lamp_i  (lamp_test_i),
    .seg_o   (seg_o)
  );

  // R3 / R9: lamp test wins over decoding and blanking
  always_comb begin
    if (lamp_test_i)
      p_lamp_all_on_r3: assert (seg_o == 7'h7F)
        else $error("p_lamp_all_on_r3: lamp test not all on");
  end

  // R4: a blanked digit is dark without lamp test
  always_comb begin
    if (!rbo_o && !lamp_test_i)
      p_blank_dark_r4: assert (seg_o == 7'h00)
        else $error("p_blank_dark_r4: blanked digit lit");
  end

  // R7: a lit display with blanking output low only happens under lamp test
  always_comb begin
    if (!rbo_o && seg_o != 7'h00)
      p_blank_only_lamp_r7: assert (lamp_test_i)
        else $error("p_blank_only_lamp_r7: blanked digit lit without lamp");
  end
endmodule

// File: tb/jc_seg_decoder_tb_top.sv
module jc_seg_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] jc = '0;
  logic       rbi = 1'b0;
  logic       lamp = 1'b0;
  logic [6:0] seg;
  logic       rbo;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  jc_seg_decoder dut_i (
    .jc_i        (jc),
    .rbi_i       (rbi),
    .lamp_test_i (lamp),
    .seg_o       (seg),
    .rbo_o       (rbo)
  );

  // digit for a code, or -1 when illegal (R2)
  function automatic int exp_digit(input logic [4:0] c);
    logic [4:0] codes [10] = '{5'b00000, 5'b00001, 5'b00011, 5'b00111, 5'b01111,
                               5'b11111, 5'b11110, 5'b11100, 5'b11000, 5'b10000};
    for (int i = 0; i < 10; i++) if (codes[i] == c) return i;
    return -1;
  endfunction

  function automatic logic [6:0] exp_seg(input logic [4:0] c, input logic r, input logic l);
    logic [6:0] pat [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                             7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    int d;
    d = exp_digit(c);
    if (l) return 7'h7F;
    if (d < 0) return 7'h00;
    if (d == 0 && !r) return 7'h00;
    return pat[d];
  endfunction

  function automatic logic exp_rbo(input logic [4:0] c, input logic r);
    return !(c == 5'b00000 && !r);
  endfunction

  task automatic apply_check(input logic [4:0] c, input logic r, input logic l, input string tag);
    logic [6:0] es;
    logic       er;
    @(posedge clk);
    jc <= c; rbi <= r; lamp <= l;
    @(negedge clk);
    es = exp_seg(c, r, l);
    er = exp_rbo(c, r);
    checks++;
    if (seg !== es) begin
      failures++;
      $display("FAIL %s seg jc=%b rbi=%b lamp=%b actual=%h expected=%h", tag, c, r, l, seg, es);
    end
    checks++;
    if (rbo !== er) begin
      failures++;
      $display("FAIL %s rbo jc=%b rbi=%b lamp=%b actual=%b expected=%b", tag, c, r, l, rbo, er);
    end
  endtask

  function automatic string tag_for(input logic [4:0] c, input logic r, input logic l);
    int d;
    d = exp_digit(c);
    if (l && d == 0 && !r) return "R9";
    if (l) return "R3";
    if (d < 0) return "R8";
    if (d == 0) return r ? "R5" : "R4";
    return "R7/R1";
  endfunction

  initial begin
    int unsigned seed;
    logic [4:0] c;
    logic r, l;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    // reset state: all inputs low, digit zero blanked (R4, R6)
    checks++;
    if (seg !== 7'h00 || rbo !== 1'b0) begin
      failures++;
      $display("FAIL R4 reset state actual=%h/%b expected=00/0", seg, rbo);
    end
    // directed corners
    apply_check(5'b00000, 1'b0, 1'b0, "R4");
    apply_check(5'b00000, 1'b1, 1'b0, "R5");
    apply_check(5'b00000, 1'b0, 1'b1, "R9");
    apply_check(5'b00000, 1'b1, 1'b1, "R5");
    apply_check(5'b11110, 1'b0, 1'b0, "R1 tail six");
    apply_check(5'b10000, 1'b0, 1'b0, "R1 tail nine");
    apply_check(5'b01010, 1'b1, 1'b0, "R8");
    apply_check(5'b01010, 1'b0, 1'b1, "R3");
    // exhaustive sweep: R2 code order, R6 independence of lamp
    for (int ci = 0; ci < 32; ci++)
      for (int m = 0; m < 4; m++)
        apply_check(5'(ci), m[0], m[1], tag_for(5'(ci), m[0], m[1]));
    // random mix
    for (int n = 0; n < 300; n++) begin
      c = 5'($urandom);
      r = 1'($urandom);
      l = (($urandom % 5) == 0);
      apply_check(c, r, l, tag_for(c, r, l));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule